// File: doc/BRIEF.md
# Priority-Masked Interrupt Acknowledge Unit

This unit decides, every cycle, whether one of N maskable interrupt sources should be taken. Each source carries a 3-bit priority level, where 0 turns the source off and 1 through 7 rank it from lowest to highest. A 3-bit processor threshold and a global enable flag gate acceptance. When a source is pending, the flag is set and the source's level is strictly above the threshold, the unit presents the winning source number and its level on the same cycle as a single-cycle acknowledge. It then drops that source's pending bit.

The threshold and the levels are written through plain write ports, and those writes do not act at once. A threshold write tagged as a return from an interrupt handler governs arbitration two cycles after the write cycle. A threshold write tagged as a register load or a pop governs it three cycles after. A level write, which models an ordinary data move, acts after a latency of two or three cycles chosen by parameter. Until a delayed write matures, arbitration uses the previous value. The enable flag acts on the cycle after its write.

Top module: `irq_prio_ack`

## Requirements
- R1: A synchronous reset clears every level, the threshold, the enable flag, all pending requests and all pending delayed writes, so `ack` is 0 in the cycle after reset.
- R2: `ack` is 1 only when the enable flag is 1, the source has a pending request and its level is strictly greater than the threshold. `ack_src` and `ack_lvl` then give that source's number and level.
- R3: A source at level 0 is never acknowledged. A threshold of 7 blocks every source. A threshold of k admits levels k+1 to 7 only, so a source whose level equals the threshold is refused.
- R4: Among eligible sources the highest level wins. On a tie in level, the lowest source number wins.
- R5: A `req_set` pulse on bit i makes source i pending from the next cycle. The acknowledge clears that source's pending bit, so each request is acknowledged exactly once.
- R6: A threshold write with `ipl_slow`=0 (return path) in cycle t leaves cycles t and t+1 on the old threshold and applies the new one from cycle t+2.
- R7: A threshold write with `ipl_slow`=1 (load or pop path) in cycle t applies the new threshold from cycle t+3. Cycles t to t+2 use the old one.
- R8: A level write in cycle t applies the new level from cycle t+MOV_LAT, with MOV_LAT equal to 2 or 3 and a default of 2. Earlier cycles use the old level.
- R9: A second write to the same register while an earlier write is still waiting discards the earlier value and restarts the delay from the second write's own cycle and tag.
- R10: The enable flag, the threshold and the levels are independent. Writing one leaves the others unchanged. An enable write in cycle t acts from cycle t+1, and requests that are already pending stay pending while the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ien_we | input | 1 | Enable-flag write strobe |
| ien_d | input | 1 | Enable-flag write value |
| ipl_we | input | 1 | Threshold write strobe |
| ipl_slow | input | 1 | Threshold write tag: 0 = return path (2 cycles), 1 = load/pop path (3 cycles) |
| ipl_d | input | 3 | Threshold write value |
| lvl_we | input | 1 | Level write strobe |
| lvl_sel | input | IW | Source number for the level write |
| lvl_d | input | 3 | Level write value |
| req_set | input | N_SRC | Request pulses, one bit per source |
| ack | output | 1 | Acknowledge, high for the cycle a source wins |
| ack_src | output | IW | Winning source number |
| ack_lvl | output | 3 | Winning source's level |

## Verification
The interesting collision is a delayed threshold or level write maturing while a request is held pending against it. Arbitration and the update then meet in the same cycle. The bench parks a request behind a blocking threshold or a zero level, writes the releasing value and samples `ack` in every cycle from the write onward. It expects the acknowledge to stay low up to the last cycle that still uses the old value and to rise exactly in the cycle the latency rule names. A second rewrite during the wait must keep the acknowledge low for good, because the later, blocking value is the one that matures.

// File: rtl/irq_prio_ack.sv
`timescale 1ns/1ps
module irq_prio_ack #(
  parameter int N_SRC   = 8,
  parameter int MOV_LAT = 2,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int LW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_we,
  input  logic             ien_d,
  input  logic             ipl_we,
  input  logic             ipl_slow,
  input  logic [LW-1:0]    ipl_d,
  input  logic             lvl_we,
  input  logic [IW-1:0]    lvl_sel,
  input  logic [LW-1:0]    lvl_d,
  input  logic [N_SRC-1:0] req_set,
  output logic             ack,
  output logic [IW-1:0]    ack_src,
  output logic [LW-1:0]    ack_lvl
);
  localparam logic [1:0] MOV_LD = 2'(MOV_LAT - 1);

  logic             ien_q;
  logic [LW-1:0]    ipl_q, ipl_nx;
  logic [1:0]       ipl_cnt;
  logic [LW-1:0]    lvl_q   [N_SRC];
  logic [LW-1:0]    lvl_nx  [N_SRC];
  logic [1:0]       lvl_cnt [N_SRC];
  logic [N_SRC-1:0] req_q, clr;

  always_ff @(posedge clk)
    if (rst)         ien_q <= 1'b0;
    else if (ien_we) ien_q <= ien_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_q   <= '0;
      ipl_nx  <= '0;
      ipl_cnt <= '0;
    end else if (ipl_we) begin
      ipl_nx  <= ipl_d;
      ipl_cnt <= ipl_slow ? 2'd2 : 2'd1;
    end else if (ipl_cnt != 2'd0) begin
      ipl_cnt <= ipl_cnt - 2'd1;
      if (ipl_cnt == 2'd1) ipl_q <= ipl_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SRC; i++) begin
      if (rst) begin
        lvl_q[i]   <= '0;
        lvl_nx[i]  <= '0;
        lvl_cnt[i] <= '0;
      end else if (lvl_we && lvl_sel == IW'(i)) begin
        lvl_nx[i]  <= lvl_d;
        lvl_cnt[i] <= MOV_LD;
      end else if (lvl_cnt[i] != 2'd0) begin
        lvl_cnt[i] <= lvl_cnt[i] - 2'd1;
        if (lvl_cnt[i] == 2'd1) lvl_q[i] <= lvl_nx[i];
      end
    end
  end

  always_comb begin
    ack     = 1'b0;
    ack_src = '0;
    ack_lvl = '0;
    for (int i = 0; i < N_SRC; i++)
      if (ien_q && req_q[i] && lvl_q[i] > ipl_q && lvl_q[i] > ack_lvl) begin
        ack     = 1'b1;
        ack_src = IW'(i);
        ack_lvl = lvl_q[i];
      end
  end

  assign clr = ack ? (N_SRC'(1) << ack_src) : '0;

  always_ff @(posedge clk)
    if (rst) req_q <= '0;
    else     req_q <= (req_q & ~clr) | req_set;
endmodule

module irq_prio_ack_chk #(
  parameter int N_SRC = 8,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ien_we,
  input logic             ien_d,
  input logic             ipl_we,
  input logic             ipl_slow,
  input logic [N_SRC-1:0] req_set,
  input logic             ack,
  input logic [IW-1:0]    ack_src,
  input logic [2:0]       ack_lvl,
  input logic [2:0]       ipl_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !ack);
  a_r3_level0_never: assert property (@(posedge clk) disable iff (rst) ack |-> ack_lvl != 3'd0);
  a_r3_ipl7_masks: assert property (@(posedge clk) disable iff (rst) ipl_q == 3'd7 |-> !ack);
  a_r2_above_ipl: assert property (@(posedge clk) disable iff (rst) ack |-> ack_lvl > ipl_q);
  a_r5_single_ack: assert property (@(posedge clk) disable iff (rst)
    ack && !req_set[ack_src] |=> !ack || ack_src != $past(ack_src));
  a_r10_ien_off: assert property (@(posedge clk) disable iff (rst) ien_we && !ien_d |=> !ack);
  a_r6_rfi_hold: assert property (@(posedge clk) disable iff (rst)
    ipl_we && !ipl_slow |=> $stable(ipl_q));
  a_r7_load_hold: assert property (@(posedge clk) disable iff (rst)
    ipl_we && ipl_slow |=> $stable(ipl_q) ##1 $stable(ipl_q));
endmodule

bind irq_prio_ack irq_prio_ack_chk #(.N_SRC(N_SRC), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .ien_we(ien_we), .ien_d(ien_d), .ipl_we(ipl_we),
  .ipl_slow(ipl_slow), .req_set(req_set), .ack(ack), .ack_src(ack_src),
  .ack_lvl(ack_lvl), .ipl_q(ipl_q)
);

// File: tb/tb_irq_prio_ack.sv
`timescale 1ns/1ps
module tb_irq_prio_ack;
  localparam int ML = 2;

  logic       clk = 0;
  logic       rst = 1;
  logic       ien_we = 0, ien_d = 0;
  logic       ipl_we = 0, ipl_slow = 0;
  logic [2:0] ipl_d = 0;
  logic       lvl_we = 0;
  logic [2:0] lvl_sel = 0, lvl_d = 0;
  logic [7:0] req_set = 0;
  logic       ack;
  logic [2:0] ack_src, ack_lvl;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ack dut (
    .clk(clk), .rst(rst), .ien_we(ien_we), .ien_d(ien_d), .ipl_we(ipl_we),
    .ipl_slow(ipl_slow), .ipl_d(ipl_d), .lvl_we(lvl_we), .lvl_sel(lvl_sel),
    .lvl_d(lvl_d), .req_set(req_set), .ack(ack), .ack_src(ack_src), .ack_lvl(ack_lvl)
  );

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic expect_ack(string r, bit a, int s = 0, int l = 0);
    #1;
    chk({r, " ack"}, int'(ack), int'(a));
    if (a) begin
      chk({r, " src"}, int'(ack_src), s);
      chk({r, " lvl"}, int'(ack_lvl), l);
    end
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) next();
  endtask

  task automatic do_reset();
    rst = 1; settle(2); rst = 0;
  endtask

  task automatic do_ien(bit v);
    ien_we = 1; ien_d = v; next(); ien_we = 0;
  endtask

  task automatic do_ipl(int v, bit slow);
    ipl_we = 1; ipl_d = 3'(v); ipl_slow = slow; next(); ipl_we = 0;
  endtask

  task automatic do_lvl(int i, int v);
    lvl_we = 1; lvl_sel = 3'(i); lvl_d = 3'(v); next(); lvl_we = 0;
  endtask

  task automatic raise(logic [7:0] m);
    req_set = m; next(); req_set = 0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_ack("R1 after reset", 0);
    raise(8'h08);
    expect_ack("R1 flag cleared by reset", 0);
  endtask

  task automatic t_basic();
    do_reset(); do_ien(1); do_lvl(3, 4); settle(3);
    raise(8'h08);
    expect_ack("R2 basic", 1, 3, 4);
    next();
    expect_ack("R5 cleared after ack", 0);
  endtask

  task automatic t_mask();
    do_reset(); do_ien(1); do_lvl(5, 0); do_lvl(3, 4); settle(3);
    raise(8'h20);
    expect_ack("R3 level zero", 0);
    do_ipl(7, 1); settle(3);
    raise(8'h08);
    expect_ack("R3 ipl 7", 0);
    do_ipl(4, 0); settle(2);
    expect_ack("R3 level equal ipl", 0);
    do_ipl(3, 0); settle(1);
    expect_ack("R3 level above ipl", 1, 3, 4);
  endtask

  task automatic t_order();
    do_reset(); do_ien(1); do_lvl(1, 6); do_lvl(2, 6); do_lvl(6, 7); settle(3);
    raise(8'b0100_0110);
    expect_ack("R4 highest first", 1, 6, 7);
    next();
    expect_ack("R4 tie low index", 1, 1, 6);
    next();
    expect_ack("R4 tie second", 1, 2, 6);
    next();
    expect_ack("R5 all served", 0);
  endtask

  task automatic t_ipl_rfi();
    do_reset(); do_ien(1); do_lvl(4, 5); do_ipl(5, 0); settle(3);
    raise(8'h10);
    expect_ack("R6 blocked", 0);
    do_ipl(2, 0);
    expect_ack("R6 t+1 old ipl", 0);
    next();
    expect_ack("R6 t+2 new ipl", 1, 4, 5);
  endtask

  task automatic t_ipl_load();
    do_reset(); do_ien(1); do_lvl(4, 5); do_ipl(7, 1); settle(3);
    raise(8'h10);
    expect_ack("R7 blocked", 0);
    do_ipl(2, 1);
    expect_ack("R7 t+1 old ipl", 0);
    next();
    expect_ack("R7 t+2 old ipl", 0);
    next();
    expect_ack("R7 t+3 new ipl", 1, 4, 5);
  endtask

  task automatic t_lvl_move();
    do_reset(); do_ien(1); settle(1);
    raise(8'h01);
    expect_ack("R8 level zero pending", 0);
    do_lvl(0, 3);
    expect_ack("R8 t+1 old level", 0);
    settle(ML - 1);
    expect_ack("R8 new level", 1, 0, 3);
  endtask

  task automatic t_rewrite();
    do_reset(); do_ien(1); do_lvl(4, 5); do_ipl(6, 0); settle(3);
    raise(8'h10);
    expect_ack("R9 blocked", 0);
    do_ipl(1, 1);
    do_ipl(6, 0);
    expect_ack("R9 t+2", 0);
    next();
    expect_ack("R9 t+3 earlier discarded", 0);
    next();
    expect_ack("R9 t+4 later value", 0);
    do_ipl(4, 0); next();
    expect_ack("R9 fresh write", 1, 4, 5);
  endtask

  task automatic t_enable();
    do_reset(); do_lvl(3, 4); do_lvl(5, 2); settle(3);
    raise(8'h08);
    expect_ack("R10 flag off", 0);
    do_ien(1);
    expect_ack("R10 flag on next cycle", 1, 3, 4);
    raise(8'h28);
    expect_ack("R10 second round", 1, 3, 4);
    do_ien(0);
    expect_ack("R10 flag off blocks", 0);
    do_ien(1);
    expect_ack("R10 levels and ipl kept", 1, 5, 2);
  endtask

  initial begin
    settle(1);
    t_reset();
    t_basic();
    t_mask();
    t_order();
    t_ipl_rfi();
    t_ipl_load();
    t_lvl_move();
    t_rewrite();
    t_enable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule